// File: doc/BRIEF.md
# Segmented I2C EEPROM Slave Controller

This block is the I2C target logic for one bus port in front of a 1 KB byte memory. It answers three bus addresses. A write-only segment pointer sits at 60h. The memory is written at A0h and read at A1h. A configuration register is written at 62h and read at 63h. The word offset is 8 bits. The block joins it with a segment number to form a 10-bit memory address.

The block handles single and sequential reads, and it handles byte and page writes through a 16-entry page buffer. The buffer is written to the memory one entry per clock, starting right after STOP. Memory sits outside the block behind a synchronous request interface: read data arrives one clock after the request. SDA is driven as open drain through an output enable.

The `HOST_PORT` parameter picks one of two address maps. The display map reaches all four 256-byte segments. The host map shows one 512-byte bank at a time. The configuration register and an external select pin pick that bank, and a write-enable bit gates host writes.

Top module: `seg_eeprom_slave`

## Requirements
- R1: The block acknowledges the address bytes 60h, A0h, A1h, 62h and 63h. It does not acknowledge any other address byte, 61h and 70h included.
- R2: A data byte written at 60h sets the segment to that byte's bits [1:0]. The segment returns to 0 at every STOP. A repeated START keeps it.
- R3: On the display map the memory address is {segment[1:0], offset[7:0]}.
- R4: During a sequential read the offset increments after each byte. It wraps from FFh to 00h inside the same segment.
- R5: Up to 16 data bytes per transaction are acknowledged and buffered. A 17th byte is not acknowledged and is dropped. The buffered bytes reach memory only after STOP.
- R6: The configuration register resets to FFh. A write at 62h is a dummy byte followed by a data byte whose bits [3:0] are stored. A read at 63h returns {4'hF, stored bits[3:0]}.
- R7: On the host map the memory address is {bank, segment[0], offset}. The bank is 0 when bit 0 (NB) is 1. Otherwise the bank is bit 1 (AB0) when bit 2 (AB1) is 1, and the select pin when AB1 is 0.
- R8: On the host map, memory data bytes are refused (not acknowledged, not stored) while bit 3 (WE) is 0. On the display map WE has no effect.
- R9: A read ends on the master's not-acknowledge. SDA is then released before the STOP.
- R10: A START or a STOP in the middle of a byte abandons that byte, and the next transaction proceeds normally.
- R11: Out of reset SDA is released and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| bank_sel_i | input | 1 | External bank select (host map only) |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 10 | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid one clock after a read request |

## Verification
A stale or wrong segment register shows up as a read from the wrong 256-byte window. This appears on the first byte of the next read, and it appears on the memory address bus one clock after the fetch. A corrupted configuration bit shows up in three ways: a wrong bank on the next access, a changed acknowledge on the next written byte, or a wrong 63h read-back. A miscounting page buffer shows up in two places: the acknowledge of the 17th byte, and memory contents compared shortly after STOP. An error in the bit counter or the acknowledge phase breaks the acknowledge of the very next byte.

// File: rtl/seg_eeprom_pkg.sv
package seg_eeprom_pkg;
  localparam int OFF_W  = 8;
  localparam int SEG_W  = 2;
  localparam int MEM_AW = OFF_W + SEG_W;

  localparam logic [6:0] DEV_SEG = 7'h30;
  localparam logic [6:0] DEV_MEM = 7'h50;
  localparam logic [6:0] DEV_CFG = 7'h31;

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_RX, ST_TX, ST_COMMIT} state_e;
  typedef enum logic [2:0] {TG_NONE, TG_SEG, TG_OFF, TG_DATA, TG_CDUMMY, TG_CDATA} target_e;
endpackage

// File: rtl/seg_eeprom_sync.sv
module seg_eeprom_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_d;
  assign scl_fall_o = ~scl_ff[1] & scl_d;
  assign start_o    = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/seg_eeprom_amap.sv
module seg_eeprom_amap
  import seg_eeprom_pkg::*;
#(
  parameter bit HOST_PORT = 1'b1
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [3:0]        cfg_i,
  input  logic              bank_sel_i,
  output logic [MEM_AW-1:0] addr_o
);
  if (HOST_PORT) begin : g_host
    logic bank;
    logic unused_seg;
    assign unused_seg = seg_i[1] ^ cfg_i[3];
    // NB forces lower bank; AB1 picks AB0 over the pin
    assign bank   = cfg_i[0] ? 1'b0 : (cfg_i[2] ? cfg_i[1] : bank_sel_i);
    assign addr_o = {bank, seg_i[0], off_i};
  end else begin : g_disp
    logic unused_cfg;
    assign unused_cfg = ^{cfg_i, bank_sel_i};
    assign addr_o = {seg_i, off_i};
  end
endmodule

// File: rtl/seg_eeprom_pagebuf.sv
module seg_eeprom_pagebuf #(
  parameter int DEPTH = 16,
  parameter int AW    = 10,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [7:0]    push_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic [7:0]    data_mem [DEPTH];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (push_i && !full_o)    cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) begin
      addr_mem[cnt_q[IW-1:0]] <= push_addr_i;
      data_mem[cnt_q[IW-1:0]] <= push_data_i;
    end
  end

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign cnt_o     = cnt_q;
  assign rd_addr_o = addr_mem[rd_idx_i];
  assign rd_data_o = data_mem[rd_idx_i];
endmodule

// File: rtl/seg_eeprom_slave.sv
module seg_eeprom_slave
  import seg_eeprom_pkg::*;
#(
  parameter bit HOST_PORT  = 1'b1,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              bank_sel_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PAGE_BYTES + 1);

  logic sda_s, scl_rise, scl_fall, start_w, stop_w;

  state_e            st_q;
  target_e           tg_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        sreg_q, tx_q;
  logic              ack_q, ackph_q, rd_q, rel_q, mack_q, src_mem_q;
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic [3:0]        cfg_q;
  logic              fetch_q, rd_pend_q;
  logic              push_q, clr_q;
  logic [MEM_AW-1:0] push_addr_q, map_addr, buf_addr;
  logic [7:0]        push_data_q, buf_data;
  logic [IW-1:0]     idx_q;
  logic [CW-1:0]     buf_cnt;
  logic              buf_full, wr_ok;
  logic              mem_req_q, mem_we_q;
  logic [MEM_AW-1:0] mem_addr_q;
  logic [7:0]        mem_wdata_q;

  seg_eeprom_sync i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w)
  );

  seg_eeprom_amap #(.HOST_PORT(HOST_PORT)) i_amap (
    .seg_i(seg_q), .off_i(off_q), .cfg_i(cfg_q), .bank_sel_i, .addr_o(map_addr)
  );

  seg_eeprom_pagebuf #(.DEPTH(PAGE_BYTES), .AW(MEM_AW)) i_buf (
    .clk_i, .rst_ni, .clear_i(clr_q), .push_i(push_q),
    .push_addr_i(push_addr_q), .push_data_i(push_data_q),
    .rd_idx_i(idx_q), .rd_addr_o(buf_addr), .rd_data_o(buf_data),
    .cnt_o(buf_cnt), .full_o(buf_full)
  );

  assign wr_ok = (!HOST_PORT || cfg_q[3]) && !buf_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;      tg_q <= TG_NONE;     bitcnt_q <= '0;
      sreg_q <= '0;         tx_q <= '0;          ack_q <= 1'b0;
      ackph_q <= 1'b0;      rd_q <= 1'b0;        rel_q <= 1'b0;
      mack_q <= 1'b0;       src_mem_q <= 1'b0;   seg_q <= '0;
      off_q <= '0;          cfg_q <= 4'hF;       fetch_q <= 1'b0;
      rd_pend_q <= 1'b0;    push_q <= 1'b0;      clr_q <= 1'b0;
      push_addr_q <= '0;    push_data_q <= '0;   idx_q <= '0;
      mem_req_q <= 1'b0;    mem_we_q <= 1'b0;    mem_addr_q <= '0;
      mem_wdata_q <= '0;
    end else begin
      mem_req_q <= 1'b0;
      mem_we_q  <= 1'b0;
      fetch_q   <= 1'b0;
      push_q    <= 1'b0;
      clr_q     <= 1'b0;
      rd_pend_q <= mem_req_q & ~mem_we_q;
      if (rd_pend_q) tx_q <= mem_rdata_i;
      if (fetch_q) begin
        mem_req_q  <= 1'b1;
        mem_addr_q <= map_addr;
      end
      if (st_q == ST_COMMIT) begin
        mem_req_q   <= 1'b1;
        mem_we_q    <= 1'b1;
        mem_addr_q  <= buf_addr;
        mem_wdata_q <= buf_data;
        idx_q       <= idx_q + IW'(1);
        if (CW'(idx_q) == buf_cnt - CW'(1)) begin
          st_q  <= ST_IDLE;
          clr_q <= 1'b1;
        end
      end else if (stop_w) begin
        st_q    <= (buf_cnt != '0) ? ST_COMMIT : ST_IDLE;
        idx_q   <= '0;
        ack_q   <= 1'b0;
        ackph_q <= 1'b0;
      end else if (start_w) begin
        st_q     <= ST_DEV;
        tg_q     <= TG_NONE;
        bitcnt_q <= '0;
        ack_q    <= 1'b0;
        ackph_q  <= 1'b0;
        rel_q    <= 1'b0;
      end else begin
        unique case (st_q)
          ST_DEV, ST_RX: begin
            if (scl_rise && bitcnt_q < 4'd8) begin
              sreg_q   <= {sreg_q[6:0], sda_s};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && bitcnt_q == 4'd8 && !ackph_q) begin
              ackph_q <= 1'b1;
              ack_q   <= 1'b0;
              if (st_q == ST_DEV) begin
                rd_q <= 1'b0;
                if (sreg_q[7:1] == DEV_SEG && !sreg_q[0]) begin
                  ack_q <= 1'b1;
                  tg_q  <= TG_SEG;
                end else if (sreg_q[7:1] == DEV_MEM) begin
                  ack_q <= 1'b1;
                  if (sreg_q[0]) begin
                    rd_q <= 1'b1; src_mem_q <= 1'b1; fetch_q <= 1'b1;
                  end else tg_q <= TG_OFF;
                end else if (sreg_q[7:1] == DEV_CFG) begin
                  ack_q <= 1'b1;
                  if (sreg_q[0]) begin
                    rd_q <= 1'b1; src_mem_q <= 1'b0; tx_q <= {4'hF, cfg_q};
                  end else tg_q <= TG_CDUMMY;
                end
              end else begin
                unique case (tg_q)
                  TG_SEG: begin
                    seg_q <= sreg_q[SEG_W-1:0]; ack_q <= 1'b1; tg_q <= TG_NONE;
                  end
                  TG_OFF: begin
                    off_q <= sreg_q; ack_q <= 1'b1; tg_q <= TG_DATA;
                  end
                  TG_DATA: if (wr_ok) begin
                    ack_q       <= 1'b1;
                    push_q      <= 1'b1;
                    push_addr_q <= map_addr;
                    push_data_q <= sreg_q;
                    off_q       <= off_q + OFF_W'(1);
                  end
                  TG_CDUMMY: begin ack_q <= 1'b1; tg_q <= TG_CDATA; end
                  TG_CDATA: begin
                    cfg_q <= sreg_q[3:0]; ack_q <= 1'b1; tg_q <= TG_NONE;
                  end
                  default: ;
                endcase
              end
            end else if (scl_fall && ackph_q) begin
              ackph_q  <= 1'b0;
              ack_q    <= 1'b0;
              bitcnt_q <= '0;
              if (!ack_q) st_q <= ST_IDLE;
              else if (rd_q) begin
                st_q   <= ST_TX;
                sreg_q <= tx_q;
                rel_q  <= 1'b0;
              end else st_q <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              if (bitcnt_q < 4'd8) bitcnt_q <= bitcnt_q + 4'd1;
              else if (bitcnt_q == 4'd8 && rel_q) begin
                mack_q   <= !sda_s;
                bitcnt_q <= 4'd9;
              end
            end else if (scl_fall) begin
              if (bitcnt_q == 4'd8 && !rel_q) begin
                rel_q <= 1'b1;
                if (src_mem_q) begin
                  off_q   <= off_q + OFF_W'(1);  // wraps inside the segment
                  fetch_q <= 1'b1;
                end
              end else if (bitcnt_q == 4'd9) begin
                if (mack_q) begin
                  sreg_q <= tx_q; bitcnt_q <= '0; rel_q <= 1'b0;
                end else st_q <= ST_IDLE;
              end else if (bitcnt_q < 4'd8) sreg_q <= {sreg_q[6:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
      if (stop_w) seg_q <= '0;
    end
  end

  assign sda_oe_o    = ack_q | (st_q == ST_TX && !rel_q && !sreg_q[7]);
  assign mem_req_o   = mem_req_q;
  assign mem_we_o    = mem_we_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_wdata_q;
endmodule

// File: rtl/seg_eeprom_chk.sv
module seg_eeprom_chk
  import seg_eeprom_pkg::*;
#(
  parameter bit HOST_PORT  = 1'b1,
  parameter int PAGE_BYTES = 16,
  localparam int CW        = $clog2(PAGE_BYTES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        st_i,
  input logic              stop_i,
  input logic [SEG_W-1:0]  seg_i,
  input logic [CW-1:0]     cnt_i,
  input logic [3:0]        cfg_i,
  input logic              sda_oe_i,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic [MEM_AW-1:0] mem_addr_i
);
  p_seg_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> seg_i == '0);

  p_page_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(PAGE_BYTES));

  p_commit_after_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_i == 3'(ST_COMMIT)) |-> $past(stop_i));

  p_lower_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HOST_PORT && mem_req_i && !mem_we_i && cfg_i[0]) |-> !mem_addr_i[MEM_AW-1]);

  p_host_we_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HOST_PORT && mem_req_i && mem_we_i) |-> cfg_i[3]);

  p_idle_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == 3'(ST_IDLE)) |-> !sda_oe_i);
endmodule

bind seg_eeprom_slave seg_eeprom_chk #(.HOST_PORT(HOST_PORT), .PAGE_BYTES(PAGE_BYTES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st_q), .stop_i(stop_w), .seg_i(seg_q),
  .cnt_i(buf_cnt), .cfg_i(cfg_q), .sda_oe_i(sda_oe_o), .mem_req_i(mem_req_o),
  .mem_we_i(mem_we_o), .mem_addr_i(mem_addr_o)
);

// File: tb/test_seg_eeprom_slave.sv
module test_seg_eeprom_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m [2];
  logic sda_m [2];
  logic [1:0] oe;
  logic bank_sel;
  logic oe_h, oe_d;
  logic req_h, we_h, req_d, we_d;
  logic [9:0] addr_h, addr_d;
  logic [7:0] wd_h, wd_d, rd_h, rd_d;
  logic [7:0] mem0 [1024];
  logic [7:0] mem1 [1024];
  logic [7:0] exp_q [$];
  int vectors = 0;
  int miscompares = 0;

  assign oe = {oe_d, oe_h};

  seg_eeprom_slave #(.HOST_PORT(1'b1)) i_seg_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m[0]), .sda_i(sda_m[0] & ~oe_h),
    .sda_oe_o(oe_h), .bank_sel_i(bank_sel), .mem_req_o(req_h), .mem_we_o(we_h),
    .mem_addr_o(addr_h), .mem_wdata_o(wd_h), .mem_rdata_i(rd_h)
  );

  seg_eeprom_slave #(.HOST_PORT(1'b0)) i_seg_eeprom_slave_disp (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m[1]), .sda_i(sda_m[1] & ~oe_d),
    .sda_oe_o(oe_d), .bank_sel_i(1'b0), .mem_req_o(req_d), .mem_we_o(we_d),
    .mem_addr_o(addr_d), .mem_wdata_o(wd_d), .mem_rdata_i(rd_d)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) begin
        mem0[i] <= pat(i);
        mem1[i] <= pat(i);
      end
    end else begin
      if (req_h) begin
        if (we_h) mem0[addr_h] <= wd_h;
        else rd_h <= mem0[addr_h];
      end
      if (req_d) begin
        if (we_d) mem1[addr_d] <= wd_d;
        else rd_d <= mem1[addr_d];
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start(int p);
    sda_m[p] = 1'b1; tick(Q);
    scl_m[p] = 1'b1; tick(Q);
    sda_m[p] = 1'b0; tick(Q);
    scl_m[p] = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop(int p);
    sda_m[p] = 1'b0; tick(Q);
    scl_m[p] = 1'b1; tick(Q);
    sda_m[p] = 1'b1; tick(4 * Q);
  endtask

  task automatic wbits(int p, logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m[p] = b[i]; tick(Q);
      scl_m[p] = 1'b1; tick(2 * Q);
      scl_m[p] = 1'b0; tick(Q);
    end
  endtask

  task automatic wr(int p, logic [7:0] b, logic exp_nack, string tag);
    logic line;
    wbits(p, b, 8);
    sda_m[p] = 1'b1; tick(Q);
    scl_m[p] = 1'b1; tick(Q);
    line = sda_m[p] & ~oe[p];
    tick(Q);
    scl_m[p] = 1'b0; tick(Q);
    chk(tag, int'(line), int'(exp_nack));
  endtask

  task automatic rbyte(int p, bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m[p] = 1'b1; tick(Q);
      scl_m[p] = 1'b1; tick(Q);
      b[i] = sda_m[p] & ~oe[p];
      tick(Q);
      scl_m[p] = 1'b0; tick(Q);
    end
    sda_m[p] = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m[p] = 1'b1; tick(2 * Q);
    scl_m[p] = 1'b0; tick(Q);
    sda_m[p] = 1'b1;
  endtask

  // monitor side of the scoreboard: pops expected bytes as they are read
  task automatic rd_bytes(int p, int n, string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rbyte(p, k < n - 1, b);
      chk(tag, int'(b), int'(exp_q.pop_front()));
    end
    tick(4);
    chk("R9 sda released after master nack", int'(oe[p]), 0);
  endtask

  task automatic rd_at(int p, logic [7:0] off, logic [7:0] e, string tag);
    i2c_start(p); wr(p, 8'hA0, 1'b0, "R1 A0 ack"); wr(p, off, 1'b0, "R1 offset ack");
    i2c_start(p); wr(p, 8'hA1, 1'b0, "R1 A1 ack");
    exp_q.push_back(e);
    rd_bytes(p, 1, tag);
    i2c_stop(p);
  endtask

  task automatic cfg_wr(int p, logic [7:0] v);
    i2c_start(p); wr(p, 8'h62, 1'b0, "R1 62h ack");
    wr(p, 8'h00, 1'b0, "R6 dummy ack"); wr(p, v, 1'b0, "R6 cfg data ack");
    i2c_stop(p);
  endtask

  task automatic cfg_rd(int p, logic [7:0] e, string tag);
    i2c_start(p); wr(p, 8'h63, 1'b0, "R1 63h ack");
    exp_q.push_back(e);
    rd_bytes(p, 1, tag);
    i2c_stop(p);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] b;
    scl_m[0] = 1'b1; scl_m[1] = 1'b1; sda_m[0] = 1'b1; sda_m[1] = 1'b1;
    bank_sel = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R11 reset sda host", int'(oe_h), 0);
    chk("R11 reset sda disp", int'(oe_d), 0);
    chk("R11 reset no request", int'(req_h | req_d), 0);

    cfg_rd(0, 8'hFF, "R6 cfg reset value");

    // host, cfg FFh: lower bank, writes enabled
    i2c_start(0); wr(0, 8'hA0, 1'b0, "R1 A0"); wr(0, 8'h10, 1'b0, "R1 off");
    wr(0, 8'hAA, 1'b0, "R5 data0"); wr(0, 8'hBB, 1'b0, "R5 data1");
    chk("R5 not written before stop", int'(mem0[10'h010]), int'(pat(10'h010)));
    i2c_stop(0); tick(40);
    chk("R5 byte0 stored", int'(mem0[10'h010]), 8'hAA);
    chk("R5 byte1 stored", int'(mem0[10'h011]), 8'hBB);

    i2c_start(0); wr(0, 8'hA0, 1'b0, "R1 A0"); wr(0, 8'h10, 1'b0, "R1 off");
    i2c_start(0); wr(0, 8'hA1, 1'b0, "R1 A1");
    exp_q.push_back(8'hAA); exp_q.push_back(8'hBB);
    rd_bytes(0, 2, "R4 sequential readback");
    i2c_stop(0);

    // page limit
    i2c_start(0); wr(0, 8'hA0, 1'b0, "R1 A0"); wr(0, 8'h40, 1'b0, "R1 off");
    for (int i = 0; i < 17; i++) wr(0, 8'(8'h80 + i), i == 16, "R5 page ack/nack");
    i2c_stop(0); tick(40);
    for (int i = 0; i < 16; i++) chk("R5 page content", int'(mem0[10'h040 + i]), 8'h80 + i);
    chk("R5 17th byte dropped", int'(mem0[10'h050]), int'(pat(10'h050)));

    i2c_start(0); wr(0, 8'h61, 1'b1, "R1 61h nack"); i2c_stop(0);
    i2c_start(0); wr(0, 8'h70, 1'b1, "R1 70h nack"); i2c_stop(0);

    // WE=0, AB1=1, AB0=1, NB=0
    cfg_wr(0, 8'h06);
    cfg_rd(0, 8'hF6, "R6 cfg readback");
    i2c_start(0); wr(0, 8'hA0, 1'b0, "R1 A0"); wr(0, 8'h20, 1'b0, "R1 off");
    wr(0, 8'h11, 1'b1, "R8 write refused when WE=0");
    i2c_stop(0); tick(40);
    chk("R8 upper cell untouched", int'(mem0[10'h220]), int'(pat(10'h220)));
    chk("R8 lower cell untouched", int'(mem0[10'h020]), int'(pat(10'h020)));
    rd_at(0, 8'h20, pat(10'h220), "R7 AB0 selects upper");

    // WE=1, AB1=0, NB=0: pin selects
    cfg_wr(0, 8'h08);
    bank_sel = 1'b1;
    rd_at(0, 8'h30, pat(10'h230), "R7 pin high upper");
    bank_sel = 1'b0;
    rd_at(0, 8'h30, pat(10'h030), "R7 pin low lower");
    bank_sel = 1'b1;

    i2c_start(0); wr(0, 8'h60, 1'b0, "R1 60h"); wr(0, 8'h01, 1'b0, "R2 seg");
    i2c_start(0); wr(0, 8'hA0, 1'b0, "R1 A0"); wr(0, 8'h05, 1'b0, "R1 off");
    i2c_start(0); wr(0, 8'hA1, 1'b0, "R1 A1");
    exp_q.push_back(pat(10'h305));
    rd_bytes(0, 1, "R2 R7 segment 1 upper bank");
    i2c_stop(0);
    rd_at(0, 8'h05, pat(10'h205), "R2 segment cleared by stop");

    // display port
    i2c_start(1); wr(1, 8'h60, 1'b0, "R1 60h"); wr(1, 8'h03, 1'b0, "R2 seg");
    i2c_start(1); wr(1, 8'hA0, 1'b0, "R1 A0"); wr(1, 8'hFE, 1'b0, "R1 off");
    i2c_start(1); wr(1, 8'hA1, 1'b0, "R1 A1");
    exp_q.push_back(pat(10'h3FE)); exp_q.push_back(pat(10'h3FF)); exp_q.push_back(pat(10'h300));
    rd_bytes(1, 3, "R3 R4 segment 3 wrap");
    i2c_stop(1);

    cfg_wr(1, 8'h00);
    i2c_start(1); wr(1, 8'h60, 1'b0, "R1 60h"); wr(1, 8'h02, 1'b0, "R2 seg");
    i2c_start(1); wr(1, 8'hA0, 1'b0, "R1 A0"); wr(1, 8'h07, 1'b0, "R1 off");
    wr(1, 8'h77, 1'b0, "R8 display ignores WE");
    i2c_stop(1); tick(40);
    chk("R3 R8 display write stored", int'(mem1[10'h207]), 8'h77);

    // aborts
    i2c_start(0); wbits(0, 8'hA0, 4); i2c_stop(0);
    cfg_rd(0, 8'hF8, "R10 after stop abort");
    i2c_start(0); wbits(0, 8'h62, 3);
    i2c_start(0); wr(0, 8'h63, 1'b0, "R10 restart ack");
    exp_q.push_back(8'hF8);
    rd_bytes(0, 1, "R10 after start abort");
    i2c_stop(0);
    rbyte(0, 1'b0, b);
    chk("R10 idle bus reads released", int'(b), 8'hFF);

    summary();
  end
endmodule